// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector memory command into a sequence of per-element memory requests, one element per cycle at most. A command gives a starting byte address, an addressing mode, a byte stride, a load/store flag and an element count. Elements are addressed by a fixed step of one 64-bit word, by a programmable byte stride, or by a per-element byte offset taken from an index stream (gather for loads, scatter for stores). Memory is modelled as word-interleaved banks. Each bank stays occupied for a fixed number of cycles after it is accessed, and the generator holds an element whose bank is still occupied. Element order is never changed, so power-of-two word strides that fold onto few banks run slower than odd strides.

Requests leave on a valid/ready pair (`req_valid`/`req_grant`). Index offsets arrive on a valid/ready pair (`idx_valid`/`idx_ready`). On both, a producer that raises valid keeps it raised, with stable data, until the cycle ready is high, and a transfer happens in a cycle where both are high. The consumer of requests may hold `req_grant` low for any number of cycles. For each accepted load element, the block returns the element number as a tag after a fixed read latency. A single-cycle `done` marks the end of the command.

Top module: `vec_agu`

## Requirements
- R1: After reset `req_valid`, `ret_valid` and `done` are low, and no request appears until a command is started.
- R2: Mode code 0 (code 3 acts the same) gives element i the byte address base + 8*i. Elements 0 .. length-1 are offered in increasing order on `req_elem`.
- R3: Mode code 1 gives element i the byte address base + i*stride, computed modulo 2^32, with the stride in bytes.
- R4: Mode code 2 gives element i the address base + offset, where the offset is the i-th value transferred on the index stream. An index value is consumed (`idx_ready` high) exactly in the cycle its element's request is accepted, and no request is offered while `idx_valid` is low.
- R5: The bank of a request is bits [6:3] of its byte address, which is the word address modulo 16. It is shown on `req_bank`.
- R6: A request accepted to a bank in cycle c keeps any request to that bank from being offered before cycle c+4. The held element is retried every cycle, and later elements never overtake it.
- R7: Once `req_valid` is high and `req_grant` is low, `req_valid` stays high and `req_addr` stays unchanged in the next cycle.
- R8: For a load, `ret_valid` is high with `ret_elem` = i exactly 12 cycles after element i is accepted. Stores produce no returns.
- R9: `done` is high for one cycle. For a store it comes in the cycle after the last request is accepted. For a load it comes in the cycle after the last element's return. In the `done` cycle the block already accepts a new command.
- R10: Lengths above 64 are treated as 64. A length of 0 produces no requests and raises `done` in the cycle after the command.
- R11: A `start` while a command is still in progress is ignored and does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| start_mode | input | 2 | 0 word step, 1 byte stride, 2 indexed, 3 as 0 |
| start_store | input | 1 | 1 for store, 0 for load |
| start_base | input | 32 | Starting byte address |
| start_stride | input | 32 | Byte stride for mode 1 |
| start_vlen | input | 7 | Element count, clipped to 64 |
| idx_valid | input | 1 | Index offset available |
| idx_ready | output | 1 | Index offset consumed |
| idx_off | input | 32 | Byte offset for the next indexed element |
| req_valid | output | 1 | Request offered |
| req_grant | input | 1 | Request accepted by memory |
| req_addr | output | 32 | Element byte address |
| req_bank | output | 4 | Target bank |
| req_elem | output | 6 | Element number |
| req_store | output | 1 | Request is a store |
| ret_valid | output | 1 | Load data return strobe |
| ret_elem | output | 6 | Element number of the return |
| done | output | 1 | Command complete pulse |

## Verification
The bench builds the block with its default parameters: 16 banks, a 4-cycle bank occupancy, a 12-cycle read latency and a 64-element maximum. With these values, a stride of 2 words spreads over eight banks and runs at full rate. A stride of 8 words alternates between two banks, and a stride of 16 words hits one bank, which makes it stall three cycles out of four. A scrambled index table makes indexed commands hit the same bank repeatedly. A length of 100 brings the clip to 64 within reach, and a gated grant pattern shows that the bank stalls and the grant stalls interact without reordering elements.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;
endpackage

// File: rtl/agu_addr_sel.sv
module agu_addr_sel
  import agu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_BANKS  = 16,
  parameter int WORD_BYTES = 8
) (
  input  amode_e                         mode,
  input  logic [ADDR_W-1:0]              base,
  input  logic [ADDR_W-1:0]              walk_addr,
  input  logic [ADDR_W-1:0]              offset,
  output logic [ADDR_W-1:0]              addr,
  output logic [$clog2(NUM_BANKS)-1:0]   bank
);
  localparam int LSB = $clog2(WORD_BYTES);
  localparam int BW  = $clog2(NUM_BANKS);

  always_comb begin
    if (mode == AM_INDEX) addr = base + offset;
    else                  addr = walk_addr;
    bank = addr[LSB +: BW];
  end
endmodule

// File: rtl/agu_bank_timer.sv
module agu_bank_timer #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hit,
  input  logic [$clog2(NUM_BANKS)-1:0]  hit_bank,
  output logic [NUM_BANKS-1:0]          free_mask
);
  localparam int CW = $clog2(BANK_BUSY + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] left_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  left_q <= '0;
      else if (hit && (hit_bank == b))             left_q <= CW'(BANK_BUSY - 1);
      else if (left_q != '0)                       left_q <= left_q - 1'b1;
    end
    assign free_mask[b] = (left_q == '0);
  end

  // R6: an accepted access never targets a bank still occupied
  assert_bank_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> free_mask[hit_bank]);
endmodule

// File: rtl/agu_tag_delay.sv
module agu_tag_delay #(
  parameter int DEPTH = 12,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag
);
  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) vld_q[0] <= 1'b0;
        else        vld_q[0] <= in_valid;
        tag_q[0] <= in_tag;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) vld_q[s] <= 1'b0;
        else        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_tag   = tag_q[DEPTH-1];
endmodule

// File: rtl/vec_agu.sv
module vec_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_BANKS  = 16,
  parameter int WORD_BYTES = 8,
  parameter int BANK_BUSY  = 4,
  parameter int RD_LATENCY = 12,
  parameter int MAX_VL     = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    start_mode,
  input  logic                          start_store,
  input  logic [ADDR_W-1:0]             start_base,
  input  logic [ADDR_W-1:0]             start_stride,
  input  logic [$clog2(MAX_VL+1)-1:0]   start_vlen,
  input  logic                          idx_valid,
  output logic                          idx_ready,
  input  logic [ADDR_W-1:0]             idx_off,
  output logic                          req_valid,
  input  logic                          req_grant,
  output logic [ADDR_W-1:0]             req_addr,
  output logic [$clog2(NUM_BANKS)-1:0]  req_bank,
  output logic [$clog2(MAX_VL)-1:0]     req_elem,
  output logic                          req_store,
  output logic                          ret_valid,
  output logic [$clog2(MAX_VL)-1:0]     ret_elem,
  output logic                          done
);
  localparam int EW = $clog2(MAX_VL);
  localparam int LW = $clog2(MAX_VL + 1);
  localparam int BW = $clog2(NUM_BANKS);

  logic              running_q, store_q, done_q;
  amode_e            mode_q;
  logic [ADDR_W-1:0] base_q, step_q, walk_q;
  logic [LW-1:0]     vlen_q, elem_q;

  logic [NUM_BANKS-1:0] free_mask;
  logic [ADDR_W-1:0]    sel_addr;
  logic [BW-1:0]        sel_bank;
  logic                 pending, need_idx, fire, last_fire, done_nxt, take;
  logic [LW-1:0]        clip_vl;

  agu_addr_sel #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORD_BYTES(WORD_BYTES)) u_sel (
    .mode(mode_q), .base(base_q), .walk_addr(walk_q), .offset(idx_off),
    .addr(sel_addr), .bank(sel_bank)
  );

  agu_bank_timer #(.NUM_BANKS(NUM_BANKS), .BANK_BUSY(BANK_BUSY)) u_banks (
    .clk(clk), .rst_n(rst_n), .hit(fire), .hit_bank(sel_bank), .free_mask(free_mask)
  );

  agu_tag_delay #(.DEPTH(RD_LATENCY), .TAG_W(EW)) u_ret (
    .clk(clk), .rst_n(rst_n), .in_valid(fire && !store_q), .in_tag(elem_q[EW-1:0]),
    .out_valid(ret_valid), .out_tag(ret_elem)
  );

  always_comb begin
    need_idx  = (mode_q == AM_INDEX);
    pending   = running_q && (elem_q < vlen_q);
    req_valid = pending && free_mask[sel_bank] && (!need_idx || idx_valid);
    fire      = req_valid && req_grant;
    idx_ready = fire && need_idx;
    last_fire = fire && (elem_q == vlen_q - LW'(1));
    clip_vl   = (start_vlen > LW'(MAX_VL)) ? LW'(MAX_VL) : start_vlen;
    take      = start && !running_q;
    done_nxt  = (running_q && store_q && last_fire)
             || (running_q && !store_q && ret_valid && ({1'b0, ret_elem} == vlen_q - LW'(1)))
             || (take && (clip_vl == '0));
  end

  assign req_addr  = sel_addr;
  assign req_bank  = sel_bank;
  assign req_elem  = elem_q[EW-1:0];
  assign req_store = store_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      store_q   <= 1'b0;
      done_q    <= 1'b0;
      mode_q    <= AM_UNIT;
      base_q    <= '0;
      step_q    <= '0;
      walk_q    <= '0;
      vlen_q    <= '0;
      elem_q    <= '0;
    end else begin
      done_q <= done_nxt;
      if (take) begin
        running_q <= (clip_vl != '0);
        store_q   <= start_store;
        mode_q    <= amode_e'(start_mode);
        base_q    <= start_base;
        walk_q    <= start_base;
        step_q    <= (amode_e'(start_mode) == AM_STRIDE) ? start_stride : ADDR_W'(WORD_BYTES);
        vlen_q    <= clip_vl;
        elem_q    <= '0;
      end else begin
        if (fire) begin
          elem_q <= elem_q + 1'b1;
          walk_q <= walk_q + step_q;
        end
        if (done_nxt) running_q <= 1'b0;
      end
    end
  end

  // R7: an offered request is held with the same address until granted
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_grant) |=> (req_valid && $stable(req_addr)));

  // R9: no request is offered in the completion cycle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R8: a store command never sees a return strobe
  assert_store_noret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && store_q) |-> !ret_valid);

  // R4: index handshake only together with an accepted request
  assert_idx_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> (req_valid && req_grant && idx_valid));
endmodule

// File: tb/vec_agu_test.sv
`timescale 1ns/1ps
module vec_agu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  start_mode;
  logic        start_store;
  logic [31:0] start_base, start_stride;
  logic [6:0]  start_vlen;
  logic        idx_valid, idx_ready;
  logic [31:0] idx_off;
  logic        req_valid, req_grant, req_store;
  logic [31:0] req_addr;
  logic [3:0]  req_bank;
  logic [5:0]  req_elem, ret_elem;
  logic        ret_valid, done;

  always #10 clk = ~clk;

  vec_agu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
    .start_store(start_store), .start_base(start_base), .start_stride(start_stride),
    .start_vlen(start_vlen), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_off(idx_off), .req_valid(req_valid), .req_grant(req_grant),
    .req_addr(req_addr), .req_bank(req_bank), .req_elem(req_elem),
    .req_store(req_store), .ret_valid(ret_valid), .ret_elem(ret_elem), .done(done)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int gmode = 0, imode = 0;
  int fires = 0;
  logic [31:0] idx_tab [64];
  int ip = 0;
  logic idx_hold = 1'b0;

  // reference model state
  logic        m_run = 1'b0, m_store = 1'b0;
  int          m_mode = 0, m_vlen = 0, m_elem = 0, m_done_at = -10;
  logic [31:0] m_base = 0, m_stride = 0;
  int          m_free [16];
  int          q_due [$];
  int          q_el  [$];

  // next-command pulse
  logic        n_start = 0, n_store = 0;
  logic [1:0]  n_mode = 0;
  logic [31:0] n_base = 0, n_stride = 0;
  logic [6:0]  n_vlen = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit          run0, ev, eret, fire_m;
    logic [31:0] ea;
    logic [3:0]  eb;
    @(negedge clk);
    start        = n_start;
    start_mode   = n_mode;
    start_store  = n_store;
    start_base   = n_base;
    start_stride = n_stride;
    start_vlen   = n_vlen;
    req_grant    = (gmode == 0) ? 1'b1 : ((cyc % 3) != 0);
    idx_valid    = idx_hold ? 1'b1 : ((imode == 0) ? 1'b1 : ((cyc % 4) != 1));
    idx_off      = idx_tab[ip % 64];
    #1;
    if (m_mode == 2)      ea = m_base + idx_tab[m_elem % 64];
    else if (m_mode == 1) ea = m_base + m_stride * 32'(m_elem);
    else                  ea = m_base + 32'(8 * m_elem);
    eb = ea[6:3];
    ev = m_run && (m_elem < m_vlen) && (cyc >= m_free[eb]) && (m_mode != 2 || idx_valid);
    eret = (q_due.size() > 0) && (q_due[0] == cyc);
    chk(req_valid == ev, "R6 req_valid offer timing", req_valid, ev);
    if (ev && req_valid) begin
      if (m_mode == 2)      chk(req_addr == ea, "R4 indexed address", req_addr, ea);
      else if (m_mode == 1) chk(req_addr == ea, "R3 strided address", req_addr, ea);
      else                  chk(req_addr == ea, "R2 word-step address", req_addr, ea);
      chk(req_bank == eb, "R5 bank select", req_bank, eb);
      chk(req_elem == 6'(m_elem), "R2 element order", req_elem, m_elem);
      chk(req_store == m_store, "R8 store flag", req_store, m_store);
    end
    chk(idx_ready == (ev && req_grant && m_mode == 2), "R4 index consume", idx_ready,
        (ev && req_grant && m_mode == 2));
    chk(ret_valid == eret, "R8 return timing", ret_valid, eret);
    if (eret && ret_valid) chk(ret_elem == 6'(q_el[0]), "R8 return tag", ret_elem, q_el[0]);
    chk(done == (m_done_at == cyc), "R9 done pulse", done, (m_done_at == cyc));
    // stream bookkeeping from ports
    if (idx_valid && idx_ready) ip++;
    idx_hold = idx_valid && !idx_ready;
    // model update
    run0 = m_run;
    fire_m = ev && req_grant;
    if (eret) begin
      if (!m_store && q_el[0] == m_vlen - 1) begin m_done_at = cyc + 1; m_run = 0; end
      void'(q_due.pop_front());
      void'(q_el.pop_front());
    end
    if (fire_m) begin
      fires++;
      m_free[eb] = cyc + 4;
      if (!m_store) begin q_due.push_back(cyc + 12); q_el.push_back(m_elem); end
      else if (m_elem == m_vlen - 1) begin m_done_at = cyc + 1; m_run = 0; end
      m_elem++;
    end
    if (n_start && !run0) begin
      m_mode = n_mode; m_store = n_store; m_base = n_base; m_stride = n_stride;
      m_vlen = (n_vlen > 64) ? 64 : int'(n_vlen);
      m_elem = 0; ip = 0;
      if (m_vlen == 0) m_done_at = cyc + 1;
      else m_run = 1;
    end
    cyc++;
  endtask

  task automatic run_op(input int mode, input bit st, input logic [31:0] base,
                        input logic [31:0] stride, input int vl, input int gm, input int im,
                        input int intr_at, input int exp_fires, input string tag);
    int lc;
    gmode = gm; imode = im; fires = 0; m_done_at = -10;
    n_start = 1; n_mode = 2'(mode); n_store = st; n_base = base; n_stride = stride;
    n_vlen = 7'(vl);
    step();
    n_start = 0;
    lc = 0;
    while (!(m_done_at >= 0 && cyc > m_done_at + 1)) begin
      if (lc == intr_at) begin
        n_start = 1; n_mode = 2'd1; n_store = ~st; n_base = 32'h8000; n_stride = 32'd24;
        n_vlen = 7'd5;
      end
      step();
      n_start = 0;
      lc++;
      if (lc > 2000) begin
        chk(1'b0, {tag, " watchdog"}, lc, 0);
        break;
      end
    end
    chk(fires == exp_fires, {tag, " accepted element count"}, fires, exp_fires);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_free[i] = 0;
    for (int i = 0; i < 64; i++) idx_tab[i] = 32'((i * i) * 8 + (i / 4) * 1024);
    rst_n = 0; start = 0; start_mode = 0; start_store = 0; start_base = 0;
    start_stride = 0; start_vlen = 0; req_grant = 0; idx_valid = 0; idx_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_valid == 0, "R1 reset req_valid", req_valid, 0);
    chk(ret_valid == 0, "R1 reset ret_valid", ret_valid, 0);
    chk(done == 0, "R1 reset done", done, 0);
    repeat (3) step();

    run_op(0, 0, 32'h1000, 0,    20, 0, 0, -1, 20, "R2 word-step load");
    run_op(1, 1, 32'h2008, 16,   16, 0, 0, -1, 16, "R3 stride-2 store");
    run_op(1, 0, 32'h0040, 64,   10, 1, 0, -1, 10, "R6 stride-8 load");
    run_op(1, 0, 32'h0000, 128,   6, 0, 0, -1,  6, "R6 stride-16 load");
    run_op(2, 0, 32'h4000, 0,    12, 1, 1, -1, 12, "R4 gather load");
    run_op(2, 1, 32'h0100, 0,     8, 0, 1, -1,  8, "R4 scatter store");
    run_op(0, 0, 32'h0008, 0,   100, 1, 0, -1, 64, "R10 length clip");
    run_op(0, 1, 32'h0000, 0,     0, 0, 0, -1,  0, "R10 zero length");
    run_op(1, 1, 32'h3000, 40,   10, 1, 0,  3, 10, "R11 start while busy");
    run_op(3, 0, 32'h0500, 0,     4, 0, 0, -1,  4, "R2 reserved mode");
    repeat (4) step();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule